// File: doc/BRIEF.md
# AGC Synchronization and Hold-off Controller

This block decides when an automatic gain control loop is resynchronized. A sync request can come from three places:

- a software strobe,
- an external pin,
- a level bit that software sets to force a sync at once.

The strobe and pin requests go through a programmable hold-off down-counter before the loop sees them. The level bit bypasses that counter.

Each delivered sync produces a one-cycle sync pulse and an update-sample pulse, and it restarts the update decimator. When the initialize option is set, the same sync also clears the averaging filter and loads a new decimation ratio. A first-sync-only option makes the block honour a single counted request and then let the loop run freely.

The gain arithmetic and the register decode sit outside the block. Register values arrive on plain input ports. Every output is registered.

Top module: `agc_sync_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, all four outputs are low. The active decimation ratio code resets to 0, which is a ratio of 1.
- R2: A soft or pin request, sampled at clock edge k with a hold-off value H of 2 or more, loads the counter. `agc_sync` is then high for the one cycle after edge k+H.
- R3: With a hold-off value of 1, a request sampled at edge k gives `agc_sync` at edge k+1. This is the shortest delay the counter path has.
- R4: With a hold-off value of 0, soft and pin requests are ignored and produce no sync.
- R5: A soft or pin request that arrives while a countdown is running reloads the counter with the current hold-off value and restarts the delay from that edge.
- R6: While `first_only` is 1, soft and pin requests are ignored once a counted sync has been delivered. The latch that records this is cleared by reset or by `agc_en` low.
- R7: A delivered sync pulses `agc_init` and `filt_clear` together with `agc_sync` when `init_on_sync` is 1. When `init_on_sync` is 0, neither of them pulses.
- R8: Every delivered sync pulses `agc_upd` in the same cycle. After that, `agc_upd` pulses every D+1 cycles, where D is the active ratio code.
- R9: The active ratio code takes `dec_ratio` only on an initializing sync. A sync with `init_on_sync` at 0 keeps the old ratio.
- R10: A 0-to-1 change on `sync_now`, sampled at edge k, gives `agc_sync` at edge k. This path ignores the hold-off value and `first_only`.
- R11: When `agc_en` is 0 at an edge, all outputs are low after that edge and any running countdown is dropped.
- R12: When a countdown expiry and a `sync_now` event fall on the same edge, they give one single-cycle sync pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| agc_en | input | 1 | Loop enable. Low clears the countdown and the first-sync latch. |
| soft_sync | input | 1 | Software sync strobe |
| pin_sync | input | 1 | External pin sync strobe |
| sync_now | input | 1 | Immediate-sync bit. Acts on its rising edge. |
| init_on_sync | input | 1 | Syncs also initialize the loop |
| first_only | input | 1 | Honour only the first counted sync |
| holdoff | input | 16 | Hold-off count. 0 blocks soft and pin requests; 1 means no extra delay. |
| dec_ratio | input | 12 | Decimation ratio code. The ratio is code+1. |
| agc_sync | output | 1 | Sync pulse to the loop |
| agc_init | output | 1 | Parameter-load pulse |
| filt_clear | output | 1 | Averaging-filter clear pulse |
| agc_upd | output | 1 | Update-sample pulse |

## Verification
The hardest situation to reach from the ports is a request that lands during a running countdown. Close behind it are a counter expiry on the very edge where `sync_now` rises, and a first-sync latch that must be released only by `agc_en`. Directed sequences place these events on exact edges, relying on the edge counts in R2, R3 and R12. A long run of sparse random strobes, short hold-off values and occasional mode and enable flips then lands many more of them by chance. A cycle-level reference model checks every output on every cycle.

// File: rtl/agc_sync_pkg.sv
package agc_sync_pkg;
  localparam int unsigned HOLD_W_DEF = 16;
  localparam int unsigned DEC_W_DEF  = 12;

  typedef struct packed {
    logic sync;
    logic init;
    logic clear;
  } agc_evt_t;
endpackage

// File: rtl/agc_sync_req.sv
// Request qualification: sync_now edge detect and the first-sync-only latch.
module agc_sync_req #(
  parameter int unsigned HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              soft_req,
  input  logic              pin_req,
  input  logic              now_bit,
  input  logic              first_only,
  input  logic [HOLD_W-1:0] holdoff,
  input  logic              fire,
  output logic              accept,
  output logic              now_evt
);
  logic now_q, now_d;
  logic done_q, done_d;

  always_comb begin
    now_d   = now_bit;
    done_d  = done_q;
    if (!en)       done_d = 1'b0;
    else if (fire) done_d = 1'b1;
    now_evt = en & now_bit & ~now_q;
    accept  = en & (soft_req | pin_req) & (holdoff != '0) & ~(first_only & done_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      now_q  <= now_d;
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/agc_holdoff_cnt.sv
// Hold-off down-counter. fire is high while the count sits at one.
module agc_holdoff_cnt #(
  parameter int unsigned HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              load,
  input  logic [HOLD_W-1:0] load_val,
  output logic              fire
);
  localparam logic [HOLD_W-1:0] ONE = HOLD_W'(1);

  logic [HOLD_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!en)               cnt_d = '0;
    else if (load)         cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - ONE;
    fire = en & (cnt_q == ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/agc_dec_timer.sv
// Update decimator: active ratio register and the free-running update counter.
module agc_dec_timer #(
  parameter int unsigned DEC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             evt,
  input  logic             init,
  input  logic [DEC_W-1:0] ratio_in,
  output logic             upd
);
  localparam logic [DEC_W-1:0] ONE = DEC_W'(1);

  logic [DEC_W-1:0] act_q, act_d;
  logic [DEC_W-1:0] left_q, left_d;
  logic             upd_q, upd_d;

  always_comb begin
    act_d  = act_q;
    left_d = left_q;
    upd_d  = 1'b0;
    if (!en) begin
      left_d = act_q;
    end else if (evt) begin
      if (init) act_d = ratio_in;
      left_d = init ? ratio_in : act_q;
      upd_d  = 1'b1;
    end else if (left_q == '0) begin
      left_d = act_q;
      upd_d  = 1'b1;
    end else begin
      left_d = left_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '0;
      left_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      act_q  <= act_d;
      left_q <= left_d;
      upd_q  <= upd_d;
    end
  end

  assign upd = upd_q;
endmodule

// File: rtl/agc_sync_ctrl.sv
module agc_sync_ctrl
  import agc_sync_pkg::*;
#(
  parameter int unsigned HOLD_W = HOLD_W_DEF,
  parameter int unsigned DEC_W  = DEC_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              agc_en,
  input  logic              soft_sync,
  input  logic              pin_sync,
  input  logic              sync_now,
  input  logic              init_on_sync,
  input  logic              first_only,
  input  logic [HOLD_W-1:0] holdoff,
  input  logic [DEC_W-1:0]  dec_ratio,
  output logic              agc_sync,
  output logic              agc_init,
  output logic              filt_clear,
  output logic              agc_upd
);
  logic     accept, now_evt, fire, evt;
  agc_evt_t ev_q, ev_d;

  agc_sync_req #(.HOLD_W(HOLD_W)) i_req (
    .clk(clk), .rst_n(rst_n), .en(agc_en), .soft_req(soft_sync), .pin_req(pin_sync),
    .now_bit(sync_now), .first_only(first_only), .holdoff(holdoff), .fire(fire),
    .accept(accept), .now_evt(now_evt)
  );

  agc_holdoff_cnt #(.HOLD_W(HOLD_W)) i_cnt (
    .clk(clk), .rst_n(rst_n), .en(agc_en), .load(accept), .load_val(holdoff), .fire(fire)
  );

  // Counter expiry and the immediate path merge into one event.
  assign evt = now_evt | fire;

  agc_dec_timer #(.DEC_W(DEC_W)) i_dec (
    .clk(clk), .rst_n(rst_n), .en(agc_en), .evt(evt), .init(init_on_sync),
    .ratio_in(dec_ratio), .upd(agc_upd)
  );

  always_comb begin
    ev_d.sync  = evt;
    ev_d.init  = evt & init_on_sync;
    ev_d.clear = evt & init_on_sync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_q <= '0;
    else        ev_q <= ev_d;
  end

  assign agc_sync   = ev_q.sync;
  assign agc_init   = ev_q.init;
  assign filt_clear = ev_q.clear;
endmodule

// File: rtl/agc_sync_ctrl_chk.sv
module agc_sync_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic agc_en,
  input logic sync_now,
  input logic agc_sync,
  input logic agc_init,
  input logic filt_clear,
  input logic agc_upd
);
  a_r11_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !agc_en |=> !(agc_sync || agc_init || filt_clear || agc_upd));
  a_r7_init_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
    agc_init |-> agc_sync);
  a_r7_clear_with_init: assert property (@(posedge clk) disable iff (!rst_n)
    filt_clear |-> agc_init);
  a_r7_init_with_clear: assert property (@(posedge clk) disable iff (!rst_n)
    agc_init |-> filt_clear);
  a_r8_update_on_sync: assert property (@(posedge clk) disable iff (!rst_n)
    agc_sync |-> agc_upd);
  a_r10_now_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (agc_en && $rose(sync_now)) |=> agc_sync);
endmodule

bind agc_sync_ctrl agc_sync_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .agc_en(agc_en), .sync_now(sync_now),
  .agc_sync(agc_sync), .agc_init(agc_init), .filt_clear(filt_clear), .agc_upd(agc_upd)
);

// File: tb/test_agc_sync_ctrl.sv
module test_agc_sync_ctrl;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, agc_en, soft_sync, pin_sync, sync_now, init_on_sync, first_only;
  logic [15:0] holdoff;
  logic [11:0] dec_ratio;
  logic        agc_sync, agc_init, filt_clear, agc_upd;

  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R1";

  int m_wait, m_dact, m_dleft;
  bit m_done, m_nowq;
  bit e_sync, e_init, e_clr, e_upd;

  agc_sync_ctrl i_agc_sync_ctrl (
    .clk(clk), .rst_n(rst_n), .agc_en(agc_en), .soft_sync(soft_sync), .pin_sync(pin_sync),
    .sync_now(sync_now), .init_on_sync(init_on_sync), .first_only(first_only),
    .holdoff(holdoff), .dec_ratio(dec_ratio), .agc_sync(agc_sync), .agc_init(agc_init),
    .filt_clear(filt_clear), .agc_upd(agc_upd)
  );

  // Reference behaviour for one edge, from the requirements.
  function automatic void model();
    bit now_ev, fire, acc, ev;
    if (!agc_en) begin
      m_wait = 0; m_done = 0; m_dleft = m_dact;
      e_sync = 0; e_init = 0; e_clr = 0; e_upd = 0;
    end else begin
      now_ev = sync_now && !m_nowq;
      fire   = (m_wait == 1);
      acc    = (soft_sync || pin_sync) && holdoff != 0 && !(first_only && m_done);
      ev     = now_ev || fire;
      m_wait = acc ? int'(holdoff) : (m_wait > 0 ? m_wait - 1 : 0);
      if (fire) m_done = 1;
      e_sync = ev;
      e_init = ev && init_on_sync;
      e_clr  = e_init;
      e_upd  = ev || (m_dleft == 0);
      if (ev) begin
        if (init_on_sync) m_dact = int'(dec_ratio);
        m_dleft = m_dact;
      end else if (m_dleft == 0) m_dleft = m_dact;
      else m_dleft = m_dleft - 1;
    end
    m_nowq = sync_now;
  endfunction

  task automatic check1(string nm, logic act, bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", cur_req, nm, act, exp);
    end
  endtask

  task automatic cyc();
    model();
    @(posedge clk);
    @(negedge clk);
    check1("agc_sync", agc_sync, e_sync);
    check1("agc_init", agc_init, e_init);
    check1("filt_clear", filt_clear, e_clr);
    check1("agc_upd", agc_upd, e_upd);
  endtask

  task automatic idle(int n);
    repeat (n) cyc();
  endtask

  task automatic req(bit use_pin);
    if (use_pin) pin_sync = 1'b1; else soft_sync = 1'b1;
    cyc();
    pin_sync = 1'b0; soft_sync = 1'b0;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_up();
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; agc_en = 0; soft_sync = 0; pin_sync = 0; sync_now = 0;
    init_on_sync = 0; first_only = 0; holdoff = 16'd1; dec_ratio = 12'd3;
    m_wait = 0; m_dact = 0; m_dleft = 0; m_done = 0; m_nowq = 0;
    #23;
    @(negedge clk);
    cur_req = "R1";
    check1("agc_sync", agc_sync, 0); check1("agc_init", agc_init, 0);
    check1("filt_clear", filt_clear, 0); check1("agc_upd", agc_upd, 0);
    rst_n = 1;
    idle(3);
    cur_req = "R8"; agc_en = 1; idle(10);
    cur_req = "R3"; holdoff = 16'd1; req(0); idle(3);
    cur_req = "R2"; holdoff = 16'd6; req(1); idle(8);
    cur_req = "R5"; holdoff = 16'd8; req(0); idle(3); req(1); idle(10);
    cur_req = "R4"; holdoff = 16'd0; req(0); idle(5); req(1); idle(20);
    cur_req = "R7"; init_on_sync = 1; dec_ratio = 12'd4; holdoff = 16'd2; req(0); idle(15);
    cur_req = "R9"; init_on_sync = 0; dec_ratio = 12'd9; holdoff = 16'd3; req(1); idle(15);
    cur_req = "R10"; holdoff = 16'd0; first_only = 1; sync_now = 1; cyc(); idle(4);
    sync_now = 0; idle(2); first_only = 0;
    cur_req = "R6"; first_only = 1; holdoff = 16'd2; req(0); idle(4); req(0); idle(6);
    req(1); idle(6); agc_en = 0; idle(2); agc_en = 1; req(0); idle(5); first_only = 0;
    cur_req = "R11"; holdoff = 16'd5; req(0); idle(2); agc_en = 0; idle(6); agc_en = 1; idle(3);
    cur_req = "R12"; init_on_sync = 1; holdoff = 16'd2; req(0); cyc(); sync_now = 1; cyc();
    sync_now = 0; idle(3); init_on_sync = 0;
    cur_req = "R2";
    for (int i = 0; i < 3000; i++) begin
      soft_sync = ($urandom % 23) == 0;
      pin_sync  = ($urandom % 31) == 0;
      if (($urandom % 40) == 0) sync_now = ~sync_now;
      if (($urandom % 50) == 0) holdoff = 16'($urandom % 12);
      if (($urandom % 60) == 0) init_on_sync = ~init_on_sync;
      if (($urandom % 200) == 0) first_only = ~first_only;
      if (($urandom % 70) == 0) dec_ratio = 12'($urandom % 8);
      agc_en = ($urandom % 300) != 0;
      cyc();
    end
    soft_sync = 0; pin_sync = 0;
    idle(5);
    finish_up();
  end
endmodule